// File: doc/BRIEF.md
# Divisor-Doubling Unsigned Divider

This block divides one unsigned word by another in two passes. First it doubles the divisor, one step per clock, and keeps each multiple in a small last-in-first-out store. It stops when the next doubled value would be larger than the dividend or would not fit in the word. Then it takes the stored multiples back, largest first, one per clock. It subtracts each multiple from the running dividend when the multiple fits, and shifts one quotient bit in on the least significant side for every step.

The number of steps depends on the operands. Small quotients finish quickly. The worst case is a divisor of one with a full-scale dividend, which takes two steps per quotient bit. A one-cycle request pulse starts an operation. A one-cycle completion pulse marks valid results. A zero divisor is rejected at once and raises an error flag.

Top module: `div_dbl_top`

## Requirements
- R1: While reset is held and after it is released, quotient_o, remainder_o, done_o and div_zero_o are all zero.
- R2: A start with divisor_i equal to zero raises done_o and div_zero_o in the cycle right after the start edge. In that case quotient_o is 0 and remainder_o equals the dividend.
- R3: For a nonzero divisor, when done_o is high, quotient_o times the divisor plus remainder_o equals the dividend, and remainder_o is less than the divisor.
- R4: When the divisor is larger than the dividend, the result is quotient 0 with remainder equal to the dividend, after a single store and a single retrieval step.
- R5: A doubled divisor equal to the running dividend counts as fitting, so doubling continues. For example, 8 divided by 4 gives quotient 2 and remainder 0.
- R6: Let k be the number of stored multiples: 1 plus the number of doublings that stay within the word and do not exceed the dividend. done_o rises exactly 2k clock edges after the edge that accepts start_i.
- R7: A doubling that would carry out of the word width ends the first pass. 0xFFFF divided by 1 gives 0xFFFF remainder 0 with k=16, and 0xFFFF divided by 0x8000 gives 1 remainder 0x7FFF with k=1.
- R8: done_o is high for one cycle. Afterwards quotient_o, remainder_o and div_zero_o keep their values until the next accepted start.
- R9: start_i is ignored while an operation is in progress. Results reflect the operands captured at the accepted start.
- R10: div_zero_o clears on the next accepted start that has a nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only when idle |
| dividend_i | input | W | Unsigned dividend, sampled on accepted start |
| divisor_i | input | W | Unsigned divisor, sampled on accepted start |
| quotient_o | output | W | Quotient, valid from done_o onward |
| remainder_o | output | W | Remainder, valid from done_o onward |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Divisor was zero for the last accepted start |

## Verification
A wrong step count or a wrong stop condition in the doubling pass shows up in two places. The completion pulse arrives at the wrong edge, which is visible within 2k cycles of the start. Quotient bits are also lost or duplicated, so the quotient times divisor plus remainder identity breaks at that same pulse. A corrupted stack entry or a wrong compare shows up as a remainder no smaller than the divisor, or as a wrong quotient, at the end of the operation. Stimulus combines directed boundary operands (equal values, powers of two, overflowing doublings, zero) with seeded random operands, and checks both the result and the exact latency of every operation.

// File: rtl/div_dbl_pkg.sv
package div_dbl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GROW   = 2'd1,
    ST_SHRINK = 2'd2
  } dd_state_e;
endpackage

// File: rtl/div_dbl_lifo.sv
module div_dbl_lifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] top_o,
  output logic [PW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] sp_q;
  logic [PW-1:0] sp_m1;

  assign sp_m1   = sp_q - PW'(1);
  assign top_o   = mem_q[sp_m1[AW-1:0]];
  assign count_o = sp_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[sp_q[AW-1:0]] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (push_i) sp_q <= sp_q + PW'(1);
    else if (pop_i)  sp_q <= sp_m1;
  end
endmodule

// File: rtl/div_dbl_step.sv
module div_dbl_step #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] dbl_o,
  output logic         grow_stop_o,
  output logic         fits_o,
  output logic [W-1:0] diff_o
);
  logic [W:0] dbl_wide;

  assign dbl_wide    = {cur_i, 1'b0};
  assign dbl_o       = dbl_wide[W-1:0];
  // equal to the running dividend still fits
  assign grow_stop_o = dbl_wide[W] | (dbl_wide[W-1:0] > rem_i);
  assign fits_o      = (top_i <= rem_i);
  assign diff_o      = rem_i - top_i;
endmodule

// File: rtl/div_dbl_fsm.sv
module div_dbl_fsm
  import div_dbl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      zero_i,
  input  logic      grow_stop_i,
  input  logic      last_pop_i,
  output dd_state_e state_o
);
  dd_state_e state_d, state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i && !zero_i) state_d = ST_GROW;
      ST_GROW:   if (grow_stop_i)        state_d = ST_SHRINK;
      ST_SHRINK: if (last_pop_i)         state_d = ST_IDLE;
      default:                           state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/div_dbl_top.sv
module div_dbl_top
  import div_dbl_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o,
  output logic         done_o,
  output logic         div_zero_o
);
  localparam int unsigned DEPTH = W;
  localparam int unsigned PW    = $clog2(DEPTH + 1);

  dd_state_e     state;
  logic [W-1:0]  cur_q, rem_q, quo_q;
  logic          done_q, dz_q;
  logic [W-1:0]  top, dbl, diff;
  logic [PW-1:0] sp;
  logic          grow_stop, fits, last_pop, zero, accept, push, pop;

  assign zero     = (divisor_i == '0);
  assign accept   = (state == ST_IDLE) && start_i;
  assign push     = (state == ST_GROW);
  assign pop      = (state == ST_SHRINK);
  assign last_pop = (sp == PW'(1));

  div_dbl_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .zero_i      (zero),
    .grow_stop_i (grow_stop),
    .last_pop_i  (last_pop),
    .state_o     (state)
  );

  div_dbl_lifo #(.DW(W), .DEPTH(DEPTH)) u_lifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .data_i  (cur_q),
    .top_o   (top),
    .count_o (sp)
  );

  div_dbl_step #(.W(W)) u_step (
    .cur_i       (cur_q),
    .rem_i       (rem_q),
    .top_i       (top),
    .dbl_o       (dbl),
    .grow_stop_o (grow_stop),
    .fits_o      (fits),
    .diff_o      (diff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        cur_q <= divisor_i;
        rem_q <= dividend_i;
        quo_q <= '0;
        dz_q  <= zero;
        if (zero) done_q <= 1'b1;
      end else if (push) begin
        if (!grow_stop) cur_q <= dbl;
      end else if (pop) begin
        if (fits) rem_q <= diff;
        quo_q <= {quo_q[W-2:0], fits};
        if (last_pop) done_q <= 1'b1;
      end
    end
  end

  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;
  assign done_o      = done_q;
  assign div_zero_o  = dz_q;
endmodule

// File: rtl/div_dbl_chk.sv
module div_dbl_chk
  import div_dbl_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned PW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input dd_state_e     state_i,
  input logic [PW-1:0] sp_i,
  input logic [W-1:0]  quotient_o,
  input logic [W-1:0]  remainder_o,
  input logic          done_o,
  input logic          div_zero_o
);
  // R2
  zero_quot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_zero_o |-> quotient_o == '0);

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> state_i == ST_IDLE);

  // R3
  rem_nonrise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE) |=> remainder_o <= $past(remainder_o));

  // R3
  quot_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SHRINK) |=> quotient_o[W-1:1] == $past(quotient_o[W-2:0]));

  // R7
  lifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_i <= PW'(W));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && $past(state_i) == ST_IDLE && !$past(done_o) && !done_o)
      |-> $stable(quotient_o) && $stable(remainder_o));
endmodule

bind div_dbl_top div_dbl_chk #(.W(W), .PW(PW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_i     (state),
  .sp_i        (sp),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o),
  .done_o      (done_o),
  .div_zero_o  (div_zero_o)
);

// File: tb/div_dbl_top_tb_top.sv
module div_dbl_top_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dvd = '0, dvs = '0;
  logic [W-1:0] quo, rem;
  logic         done, dz;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  div_dbl_top #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dividend_i(dvd), .divisor_i(dvs),
    .quotient_o(quo), .remainder_o(rem),
    .done_o(done), .div_zero_o(dz)
  );

  function automatic int exp_k(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] m;
    int k;
    if (b > a) return 1;
    k = 1;
    m = {1'b0, b};
    while ((m << 1) <= {1'b0, a} && !(m[W-1])) begin
      m = m << 1;
      k++;
    end
    return k;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input string req,
                     input bit ck_lat);
    int lat;
    int k;
    @(negedge clk);
    dvd = a; dvs = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    if (b == 0) begin
      chk({req, " R2 dz"}, 32'(dz), 1);
      chk({req, " R2 q"}, 32'(quo), 0);
      chk({req, " R2 r"}, 32'(rem), 32'(a));
      chk({req, " R2 lat"}, 32'(lat), 0);
    end else begin
      k = exp_k(a, b);
      chk({req, " R3 q"}, 32'(quo), 32'(a / b));
      chk({req, " R3 r"}, 32'(rem), 32'(a % b));
      chk({req, " R10 dz"}, 32'(dz), 0);
      if (ck_lat) chk({req, " R6 lat"}, 32'(lat), 32'(2 * k));
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] q0, r0;
    void'($urandom(32'h5eed));
    #1;
    chk("R1 q", 32'(quo), 0);
    chk("R1 done", 32'(done), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 q", 32'(quo), 0);
    chk("R1 r", 32'(rem), 0);
    chk("R1 dz", 32'(dz), 0);

    run(16'd2246, 16'd51, "basic", 1);
    run(16'd5, 16'd9, "R4 small", 1);
    chk("R4 q", 32'(quo), 0);
    run(16'd8, 16'd4, "R5 eq", 1);
    chk("R5 q", 32'(quo), 2);
    run(16'd7, 16'd7, "R5 same", 1);
    run(16'hFFFF, 16'd1, "R7 max", 1);
    chk("R7 q", 32'(quo), 32'hFFFF);
    run(16'hFFFF, 16'h8000, "R7 top", 1);
    chk("R7 r", 32'(rem), 32'h7FFF);
    run(16'h8000, 16'h8000, "R7 eq", 1);
    run(16'd1234, 16'd0, "R2 zero", 1);
    run(16'd0, 16'd3, "R10 zdvd", 1);
    chk("R10 dz clear", 32'(dz), 0);

    // R8: pulse width and hold
    q0 = quo; r0 = rem;
    @(negedge clk);
    chk("R8 pulse", 32'(done), 0);
    repeat (3) @(negedge clk);
    chk("R8 hold q", 32'(quo), 32'(q0));
    chk("R8 hold r", 32'(rem), 32'(r0));

    // R9: start while busy is ignored
    @(negedge clk);
    dvd = 16'd1000; dvs = 16'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    dvd = 16'd77; dvs = 16'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R9 q", 32'(quo), 333);
    chk("R9 r", 32'(rem), 1);
    chk("R9 dz", 32'(dz), 0);

    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom) >> ($urandom % W);
      if (i % 50 == 0) b = '0;
      run(a, b, "R3 rand", 1);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule